// File: doc/BRIEF.md
# UART Receive Error Status Unit

This unit holds the four receive-side error flags of a UART: overrun, start-bit noise, framing and parity. It sits between the receive path and the register interface. On every completed character it decides whether the character goes into the receive storage (FIFO or data register) or is dropped on overrun. It latches the error conditions that belong to an accepted character. From the flags and the software enables it forms one registered error interrupt request.

Software reads the flags as a 4-bit status word and clears them by writing ones to a separate clear word. A small control word holds the interrupt enables and the overrun disable. When overrun detection is off, a character that arrives while storage is full is written anyway, and the overrun flag reads as zero. Noise on its own never interrupts in normal operation, because the character-available event already covers it. Noise does interrupt in DMA mode when the error interrupt enable is set.

Top module: `uart_rxerr_status`

## Requirements
- R1: The overrun flag (status bit 3) sets one cycle after `rx_done` is high while `fifo_full` is high and overrun disable (control bit 3) is 0.
- R2: `char_wr` equals `rx_done` when storage is not full. On an overrun, `char_drop` is high and `char_wr` is low, so the stored data is kept and the new character is lost.
- R3: While overrun disable is 1, status bit 3 reads 0, no overrun is recorded, and a character that arrives while storage is full is written (`char_wr`=1, `char_drop`=0).
- R4: The flags are cleared only through the clear word. Writing 1 to clear bit n (3 overrun, 2 noise, 1 framing, 0 parity) clears status bit n on the next edge. Writing 0 has no effect.
- R5: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R6: The overrun flag requests an interrupt when the receive-not-empty enable (control bit 0) or the error enable (control bit 1) is 1.
- R7: The noise flag (status bit 2) sets for an accepted character with `noise_det`. It requests an interrupt only when `dma_mode` is 1 and the error enable is 1.
- R8: The framing flag (status bit 1) sets for an accepted character with `frame_err` or `break_det`. It requests an interrupt when the error enable is 1.
- R9: The parity flag (status bit 0) sets for an accepted character with `parity_err`. It requests an interrupt when the parity enable (control bit 2) is 1.
- R10: A dropped character sets none of the noise, framing or parity flags, because those flags belong to the character held in storage.
- R11: `irq_o` is a register. It follows the enabled flag conditions one cycle late and stays high until every contributing flag is cleared or its enable is removed.
- R12: After reset the status, the control word and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | 1 | One-cycle strobe: a character is complete |
| fifo_full | input | 1 | Receive storage has no free entry |
| noise_det | input | 1 | Noise seen on the start bit of this character |
| frame_err | input | 1 | Desynchronisation or bad stop bit on this character |
| break_det | input | 1 | This character is a break |
| parity_err | input | 1 | Parity mismatch on this character |
| dma_mode | input | 1 | Multi-buffer (DMA) reception is active |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control word: 3 overrun disable, 2 parity enable, 1 error enable, 0 receive-not-empty enable |
| clr_we | input | 1 | Write strobe for the clear word |
| clr_wdata | input | 4 | Clear bits, in the same positions as the status bits |
| char_wr | output | 1 | Write the completed character into storage |
| char_drop | output | 1 | Completed character discarded on overrun |
| status_o | output | 4 | Flags: 3 overrun, 2 noise, 1 framing, 0 parity |
| ctrl_o | output | 4 | Current control word |
| irq_o | output | 1 | Registered error interrupt request |

## Verification
The assertions check the following on every cycle:
- overrun sets its flag and suppresses the write;
- disabled overrun always reads zero;
- a framing or break condition on an accepted character always lands in its flag;
- idle cycles leave the flags unchanged;
- noise alone outside DMA mode never raises the request.

Some behaviours only the bench scenarios can show:
- the set-over-clear priority;
- writing zeros to the clear word has no effect;
- dropped characters leave the per-character flags alone;
- the interrupt persists until the last contributing flag or enable goes away.

// File: rtl/uart_rxerr_pkg.sv
package uart_rxerr_pkg;
   localparam int FLAG_W = 4;
   localparam int CTRL_W = 4;

   localparam int FLG_PAR = 0;
   localparam int FLG_FRM = 1;
   localparam int FLG_NSE = 2;
   localparam int FLG_OVR = 3;

   localparam int CTL_RXNE_IE = 0;
   localparam int CTL_ERR_IE  = 1;
   localparam int CTL_PAR_IE  = 2;
   localparam int CTL_OVR_DIS = 3;

   typedef struct packed {
      logic ovr;
      logic nse;
      logic frm;
      logic par;
   } err_flags_t;
endpackage

// File: rtl/rxerr_accept.sv
module rxerr_accept (
   input  logic rx_done,
   input  logic fifo_full,
   input  logic ovr_dis,
   output logic char_wr,
   output logic char_drop
);
   logic blocked;

   always_comb begin
      blocked   = fifo_full & ~ovr_dis;
      char_wr   = rx_done & ~blocked;
      char_drop = rx_done & blocked;
   end
endmodule

// File: rtl/rxerr_flag_cell.sv
module rxerr_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic zero_i,
   output logic q
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_prio
         always_comb begin
            if (set_i)      nxt = 1'b1;
            else if (clr_i) nxt = 1'b0;
            else            nxt = q;
         end
      end else begin : g_clr_prio
         always_comb begin
            if (clr_i)      nxt = 1'b0;
            else if (set_i) nxt = 1'b1;
            else            nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (zero_i) q <= 1'b0;
      else             q <= nxt;
   end
endmodule

// File: rtl/rxerr_irq.sv
module rxerr_irq
   import uart_rxerr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] flags,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              dma_mode,
   output logic              irq
);
   logic [FLAG_W-1:0] want;
   logic              any;

   always_comb begin
      want           = '0;
      want[FLG_OVR]  = flags[FLG_OVR] & (ctrl[CTL_RXNE_IE] | ctrl[CTL_ERR_IE]);
      want[FLG_NSE]  = flags[FLG_NSE] & dma_mode & ctrl[CTL_ERR_IE];
      want[FLG_FRM]  = flags[FLG_FRM] & ctrl[CTL_ERR_IE];
      want[FLG_PAR]  = flags[FLG_PAR] & ctrl[CTL_PAR_IE];
      any            = |want;
   end

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any;
         end
      end else begin : g_comb
         assign irq = any;
      end
   endgenerate
endmodule

// File: rtl/uart_rxerr_status.sv
module uart_rxerr_status
   import uart_rxerr_pkg::*;
#(
   parameter bit              SET_WINS = 1'b1,
   parameter bit              IRQ_REG  = 1'b1,
   parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic              fifo_full,
   input  logic              noise_det,
   input  logic              frame_err,
   input  logic              break_det,
   input  logic              parity_err,
   input  logic              dma_mode,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              clr_we,
   input  logic [FLAG_W-1:0] clr_wdata,
   output logic              char_wr,
   output logic              char_drop,
   output logic [FLAG_W-1:0] status_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              irq_o
);
   localparam int MAXBIT = (FLAG_W > CTRL_W) ? FLAG_W : CTRL_W;

   generate
      if (FLAG_W != 4) begin : g_bad_flag_w
         $error("status word must be four bits wide");
      end
      if (MAXBIT <= CTL_OVR_DIS) begin : g_bad_ctrl_w
         $error("control word too narrow for overrun disable");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic              ovr_dis;
   err_flags_t        set_v;
   logic [FLAG_W-1:0] set_bits;
   logic [FLAG_W-1:0] clr_bits;
   logic [FLAG_W-1:0] zero_bits;
   logic [FLAG_W-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (ctrl_we) ctrl_q <= ctrl_wdata;
   end

   assign ovr_dis = ctrl_q[CTL_OVR_DIS];

   rxerr_accept u_accept (
      .rx_done   (rx_done),
      .fifo_full (fifo_full),
      .ovr_dis   (ovr_dis),
      .char_wr   (char_wr),
      .char_drop (char_drop)
   );

   always_comb begin
      set_v.ovr = char_drop;
      set_v.nse = char_wr & noise_det;
      set_v.frm = char_wr & (frame_err | break_det);
      set_v.par = char_wr & parity_err;
      set_bits  = set_v;
      clr_bits  = clr_we ? clr_wdata : '0;
      zero_bits = '0;
      zero_bits[FLG_OVR] = ovr_dis;
   end

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         rxerr_flag_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_bits[i]),
            .clr_i  (clr_bits[i]),
            .zero_i (zero_bits[i]),
            .q      (flag_q[i])
         );
      end
   endgenerate

   always_comb begin
      status_o          = flag_q;
      status_o[FLG_OVR] = flag_q[FLG_OVR] & ~ovr_dis;
   end

   assign ctrl_o = ctrl_q;

   rxerr_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (status_o),
      .ctrl     (ctrl_q),
      .dma_mode (dma_mode),
      .irq      (irq_o)
   );
endmodule

// File: rtl/uart_rxerr_status_chk.sv
module uart_rxerr_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_done,
   input logic       fifo_full,
   input logic       frame_err,
   input logic       break_det,
   input logic       dma_mode,
   input logic       clr_we,
   input logic       char_wr,
   input logic       char_drop,
   input logic [3:0] status_o,
   input logic [3:0] ctrl_o,
   input logic       irq_o
);
   a_r1_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && fifo_full && !ctrl_o[3]) |=> status_o[3]);

   a_r2_ovr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && fifo_full && !ctrl_o[3]) |-> (char_drop && !char_wr));

   a_r3_ovr_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[3] |-> !status_o[3]);

   a_r8_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (char_wr && (frame_err || break_det)) |=> status_o[1]);

   a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_done && !clr_we) |=> (status_o[2:0] == $past(status_o[2:0])));

   a_r7_noise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 4'b0100 && !dma_mode) |=> !irq_o);

   a_r11_frame_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[1] && ctrl_o[1]) |=> irq_o);
endmodule

bind uart_rxerr_status uart_rxerr_status_chk u_chk (.*);

// File: tb/sim_uart_rxerr_status.sv
`timescale 1ns/1ps
module sim_uart_rxerr_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_done = 0, fifo_full = 0, noise_det = 0, frame_err = 0;
   logic       break_det = 0, parity_err = 0, dma_mode = 0;
   logic       ctrl_we = 0, clr_we = 0;
   logic [3:0] ctrl_wdata = '0, clr_wdata = '0;
   logic       char_wr, char_drop, irq_o;
   logic [3:0] status_o, ctrl_o;

   always #2.5 clk = ~clk;

   uart_rxerr_status u0 (.*);

   typedef struct {
      logic [3:0] st;
      logic       irq;
      string      tag;
   } exp_t;
   exp_t scb[$];

   int errors = 0, checks = 0;
   logic [3:0] e_fl = '0, e_ct = '0;
   logic       e_irq = 1'b0;

   // staged stimulus for the next cycle
   logic s_done = 0, s_full = 0, s_nse = 0, s_fe = 0, s_brk = 0, s_par = 0, s_dma = 0;
   logic s_cwe = 0, s_lwe = 0;
   logic [3:0] s_cd = '0, s_ld = '0;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(string tag);
      logic acc, drp, ovd;
      logic [3:0] set, nf, nc;
      exp_t it;
      @(negedge clk);
      rx_done = s_done; fifo_full = s_full; noise_det = s_nse; frame_err = s_fe;
      break_det = s_brk; parity_err = s_par; dma_mode = s_dma;
      ctrl_we = s_cwe; ctrl_wdata = s_cd; clr_we = s_lwe; clr_wdata = s_ld;
      #1;
      ovd = e_ct[3];
      acc = s_done & (~s_full | ovd);
      drp = s_done & s_full & ~ovd;
      chk(char_wr == acc, {tag, " R2 char_wr"}, char_wr, acc);
      chk(char_drop == drp, {tag, " R2 char_drop"}, char_drop, drp);
      // interrupt from currently visible flags (R11)
      e_irq = (e_fl[3] & (e_ct[0] | e_ct[1])) | (e_fl[2] & s_dma & e_ct[1])
            | (e_fl[1] & e_ct[1]) | (e_fl[0] & e_ct[2]);
      set = {drp, acc & s_nse, acc & (s_fe | s_brk), acc & s_par};
      nf  = set | (e_fl & ~(s_lwe ? s_ld : 4'b0));
      if (ovd) nf[3] = 1'b0;
      nc  = s_cwe ? s_cd : e_ct;
      if (nc[3]) nf[3] = 1'b0;
      e_fl = nf; e_ct = nc;
      it.st = e_fl; it.irq = e_irq; it.tag = tag;
      scb.push_back(it);
      s_done = 0; s_nse = 0; s_fe = 0; s_brk = 0; s_par = 0;
      s_cwe = 0; s_lwe = 0; s_cd = '0; s_ld = '0;
   endtask

   task automatic idle(int n, string tag);
      for (int k = 0; k < n; k++) tick(tag);
   endtask

   // monitor: pops expectations after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (scb.size() > 0) begin
            exp_t it;
            it = scb.pop_front();
            chk(status_o == it.st, {it.tag, " status"}, status_o, it.st);
            chk(irq_o == it.irq, {it.tag, " irq"}, irq_o, it.irq);
            chk(ctrl_o == e_ct, {it.tag, " ctrl"}, ctrl_o, e_ct);
         end
      end
   end

   bit finished = 0;
   initial begin
      #(5 * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1;
      chk(status_o == 4'h0, "R12 reset status", status_o, 0);
      chk(irq_o == 1'b0, "R12 reset irq", irq_o, 0);
      chk(ctrl_o == 4'h0, "R12 reset ctrl", ctrl_o, 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      idle(2, "R12 idle");

      // parity without enable, then enable it
      s_done = 1; s_par = 1; tick("R9 parity set");
      idle(2, "R9 no enable");
      s_cwe = 1; s_cd = 4'b0100; tick("R9 enable");
      idle(2, "R11 parity irq held");
      s_lwe = 1; s_ld = 4'b0000; tick("R4 zero clear");
      s_lwe = 1; s_ld = 4'b0001; tick("R4 clear parity");
      idle(2, "R11 irq drop");

      // framing and break
      s_cwe = 1; s_cd = 4'b0010; tick("R8 err enable");
      s_done = 1; s_fe = 1; tick("R8 framing");
      idle(1, "R8 irq");
      s_lwe = 1; s_ld = 4'b0010; tick("R4 clear frame");
      s_done = 1; s_brk = 1; tick("R8 break");
      idle(1, "R8 break irq");
      s_cwe = 1; s_cd = 4'b0000; tick("R11 enable removed");
      idle(1, "R11 off");
      s_lwe = 1; s_ld = 4'b1111; tick("R4 clear all");

      // noise
      s_cwe = 1; s_cd = 4'b0010; tick("R7 err enable");
      s_done = 1; s_nse = 1; tick("R7 noise normal");
      idle(2, "R7 no irq normal");
      s_dma = 1; idle(2, "R7 dma irq");
      s_dma = 0; s_lwe = 1; s_ld = 4'b0100; tick("R4 clear noise");
      idle(1, "R7 quiet");

      // overrun
      s_cwe = 1; s_cd = 4'b0001; tick("R6 rxne enable");
      s_full = 1; s_done = 1; s_par = 1; s_nse = 1; s_fe = 1; tick("R1 overrun");
      idle(1, "R10 dropped no flags");
      idle(1, "R6 ovr irq");
      s_done = 1; tick("R1 overrun again");
      s_lwe = 1; s_ld = 4'b1000; tick("R4 clear ovr");
      idle(1, "R6 irq off");
      s_done = 1; s_lwe = 1; s_ld = 4'b1000; tick("R5 set beats clear ovr");
      s_full = 0; s_done = 1; s_par = 1; s_lwe = 1; s_ld = 4'b0001; tick("R5 set beats clear par");
      s_lwe = 1; s_ld = 4'b1111; tick("R4 clear all 2");

      // overrun disable
      s_full = 1; s_done = 1; tick("R1 ovr before disable");
      s_cwe = 1; s_cd = 4'b1011; tick("R3 disable masks");
      s_done = 1; s_fe = 1; tick("R3 full written");
      idle(2, "R3 no ovr");
      s_cwe = 1; s_cd = 4'b0011; tick("R3 re-enable stays 0");
      s_full = 0; s_lwe = 1; s_ld = 4'b1111; tick("R4 final clear");
      idle(2, "R11 final idle");
      repeat (2) @(posedge clk);
      #3;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule